// File: doc/BRIEF.md
# Double-Buffer Transmit Ingress Controller

This block sits on the device side of a host-to-device transmit path. It owns two equal packet buffers. The host fills them strictly in turn, and a downstream consumer empties them in the same turn order. The host first reads a status word to learn how far the device has drained. It then writes a descriptor word followed by payload words into the buffer currently open for filling, and rings a doorbell. The doorbell advances a free-running input packet counter.

On the other side, the block presents the oldest filled buffer to the consumer. With it go the rounded length taken from that buffer's descriptor and a combinational word read port. When the consumer pulses done, the output packet counter advances and the buffer is free again. Flow control depends only on the modular difference of the two 4-bit counters. A difference of 0 means empty and a difference of 2 means full. A doorbell or a write that arrives while the buffers are full is discarded, and the doorbell also raises a one-cycle overflow flag.

Top module: `dbuf_tx_ingress`

## Requirements
- R1: After reset, both counters are 0, status_o is 0, fill_buf_o and drain_buf_o are 0, and ready_o and overflow_o are 0.
- R2: A doorbell while occupancy (input count minus output count, modulo 16) is below 2 advances the input count by one in the next cycle. fill_buf_o always equals bit 0 of the input count, so successive packets alternate between buffers 0 and 1.
- R3: A doorbell while occupancy is 2 leaves the input count unchanged and sets overflow_o high for exactly the following cycle. The full decision uses the occupancy from before any done in the same cycle.
- R4: A host write (wr_en_i) while occupancy is 2 changes neither the stored words nor the stored length of any buffer.
- R5: ready_o is high exactly when occupancy is non-zero. drain_buf_o equals bit 0 of the output count, so buffers drain in fill order.
- R6: done_i while ready_o is high advances the output count by one in the next cycle. done_i while ready_o is low has no effect.
- R7: A write to word address 0 stores bits [15:0] of the data as the packet length of the fill buffer. len_o shows that length for the drain buffer, rounded up to the next multiple of 4 and 17 bits wide, so it cannot wrap.
- R8: rd_data_o returns, in the same cycle, the word at rd_addr_i of the drain buffer.
- R9: status_o[3:0] holds the output count and status_o[7:4] holds the input count. Both wrap from 15 to 0, and the full and empty decisions stay correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host word write strobe into the fill buffer |
| wr_addr_i | input | 4 | Word address within the buffer (0 = descriptor) |
| wr_data_i | input | 32 | Host write data |
| doorbell_i | input | 1 | Host packet-committed pulse |
| status_o | output | 8 | {input count, output count} |
| fill_buf_o | output | 1 | Buffer the host fills next |
| overflow_o | output | 1 | Doorbell dropped because the buffers were full |
| ready_o | output | 1 | A filled buffer awaits the consumer |
| drain_buf_o | output | 1 | Buffer presented to the consumer |
| len_o | output | 17 | Rounded packet length of the drain buffer |
| rd_addr_i | input | 4 | Consumer word read address |
| rd_data_o | output | 32 | Word at rd_addr_i in the drain buffer |
| done_i | input | 1 | Consumer has finished the drain buffer |

## Verification
The assertions check on every cycle that occupancy never exceeds two, that each counter moves only by +1, and that a doorbell arriving when full leaves the input count untouched. They also check that done while empty is ignored and that a blocked write leaves the stored lengths unchanged. Only the bench's scenarios can show the data path end to end. It confirms that the alternating buffers hold the right words and lengths, that the length rounding is correct, and that a write attempted while full does not corrupt the buffer the consumer is currently draining. The bench also runs the packet sequence past the 4-bit counter wrap more than once.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  localparam int unsigned NUM_BUF = 2;

  function automatic logic [16:0] round_len4(input logic [15:0] len);
    logic [16:0] sum;
    sum = {1'b0, len} + 17'd3;
    return {sum[16:2], 2'b00};
  endfunction
endpackage

// File: rtl/dbuf_ptrs.sv
module dbuf_ptrs #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             doorbell_i,
  input  logic             done_i,
  output logic [CNT_W-1:0] in_cnt_o,
  output logic [CNT_W-1:0] out_cnt_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             overflow_o
);
  import dbuf_pkg::*;

  logic [CNT_W-1:0] in_q, out_q, occ;
  logic             ovf_q;

  assign occ     = in_q - out_q;  // modular, correct across wrap
  assign full_o  = (occ >= CNT_W'(NUM_BUF));
  assign empty_o = (occ == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      out_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= doorbell_i && full_o;
      if (doorbell_i && !full_o) in_q <= in_q + 1'b1;
      if (done_i && !empty_o)    out_q <= out_q + 1'b1;
    end
  end

  assign in_cnt_o   = in_q;
  assign out_cnt_o  = out_q;
  assign overflow_o = ovf_q;

  assert_occ_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= CNT_W'(NUM_BUF));
  assert_in_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_q != $past(in_q)) |-> (in_q == $past(in_q) + 1'b1));
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (in_q == $past(in_q)));
  assert_done_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && occ != '0) |=> (out_q == $past(out_q) + 1'b1));
  assert_done_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && occ == '0) |=> (out_q == $past(out_q)));
endmodule

// File: rtl/dbuf_store.sv
module dbuf_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned LEN_W  = 16,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_ok_i,
  input  logic              wr_buf_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_buf_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [LEN_W-1:0]  len_o
);
  import dbuf_pkg::*;

  logic [NUM_BUF-1:0][LEN_W-1:0]  len_q;
  logic [NUM_BUF-1:0][DATA_W-1:0] rd_word;
  logic                           wr_go;

  assign wr_go = wr_en_i && wr_ok_i;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic [DATA_W-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wr_go && (wr_buf_i == b[0])) mem_q[wr_addr_i] <= wr_data_i;
    end
    assign rd_word[b] = mem_q[rd_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
    end else if (wr_go && (wr_addr_i == '0)) begin
      for (int b = 0; b < NUM_BUF; b++)
        if (wr_buf_i == b[0]) len_q[b] <= wr_data_i[LEN_W-1:0];
    end
  end

  assign rd_data_o = rd_word[rd_buf_i];
  assign len_o     = len_q[rd_buf_i];

  assert_blocked_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_ok_i) |=> (len_q == $past(len_q)));
endmodule

// File: rtl/dbuf_tx_ingress.sv
module dbuf_tx_ingress #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CNT_W  = 4,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              doorbell_i,
  output logic [2*CNT_W-1:0] status_o,
  output logic              fill_buf_o,
  output logic              overflow_o,
  output logic              ready_o,
  output logic              drain_buf_o,
  output logic [LEN_W:0]    len_o,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              done_i
);
  import dbuf_pkg::*;

  logic [CNT_W-1:0] in_cnt, out_cnt;
  logic             full, empty;
  logic [LEN_W-1:0] raw_len;

  dbuf_ptrs #(.CNT_W(CNT_W)) i_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .doorbell_i (doorbell_i),
    .done_i     (done_i),
    .in_cnt_o   (in_cnt),
    .out_cnt_o  (out_cnt),
    .full_o     (full),
    .empty_o    (empty),
    .overflow_o (overflow_o)
  );

  dbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_ok_i   (!full),
    .wr_buf_i  (in_cnt[0]),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_buf_i  (out_cnt[0]),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .len_o     (raw_len)
  );

  assign status_o    = {in_cnt, out_cnt};
  assign fill_buf_o  = in_cnt[0];
  assign drain_buf_o = out_cnt[0];
  assign ready_o     = !empty;
  assign len_o       = round_len4(raw_len);

  assert_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (fill_buf_o == drain_buf_o) == full);
endmodule

// File: tb/test_dbuf_tx_ingress.sv
module test_dbuf_tx_ingress;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, doorbell = 1'b0, done = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [7:0]  status;
  logic        fill_buf, overflow, ready, drain_buf;
  logic [16:0] len;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_in = 0, exp_out = 0;
  logic [15:0] exp_len [2];
  logic [31:0] exp_tag [2];

  always #5 clk = ~clk;

  dbuf_tx_ingress i_dbuf_tx_ingress (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .doorbell_i(doorbell), .status_o(status),
    .fill_buf_o(fill_buf), .overflow_o(overflow), .ready_o(ready),
    .drain_buf_o(drain_buf), .len_o(len), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .done_i(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int occ();
    return (exp_in - exp_out) & 15;
  endfunction

  function automatic logic [16:0] rnd(input logic [15:0] l);
    return 17'((int'(l) + 3) / 4 * 4);
  endfunction

  task automatic host_wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ring();
    bit was_full;
    was_full = (occ() >= 2);
    doorbell = 1'b1;
    @(negedge clk);
    doorbell = 1'b0;
    if (was_full) begin
      chk(overflow == 1'b1, "R3 overflow flag", overflow, 1);
      chk(status[7:4] == 4'(exp_in), "R3 in count held", status[7:4], exp_in & 15);
    end else begin
      exp_in++;
      chk(overflow == 1'b0, "R2 no overflow", overflow, 0);
      chk(status[7:4] == 4'(exp_in), "R2 in count step", status[7:4], exp_in & 15);
      chk(fill_buf == 1'(exp_in), "R2 fill alternates", fill_buf, exp_in & 1);
    end
  endtask

  task automatic push(input int k);
    logic [15:0] l;
    int b;
    l = 16'((k * 37 + 5) % 1500 + 1);
    b = exp_in & 1;
    host_wr(4'd0, {16'hC0DE, l});
    host_wr(4'd2, 32'hA000_0000 + 32'(k));
    exp_len[b] = l;
    exp_tag[b] = 32'hA000_0000 + 32'(k);
    ring();
  endtask

  task automatic drain();
    int b;
    b = exp_out & 1;
    chk(ready == (occ() != 0), "R5 ready", ready, occ() != 0);
    chk(drain_buf == 1'(b), "R5 drain order", drain_buf, b);
    chk(len == rnd(exp_len[b]), "R7 rounded len", len, rnd(exp_len[b]));
    rd_addr = 4'd2;
    #1;
    chk(rd_data == exp_tag[b], "R8 read word", rd_data, exp_tag[b]);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    exp_out++;
    chk(status == {4'(exp_in), 4'(exp_out)}, "R9 status", status, {4'(exp_in), 4'(exp_out)});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected <100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(status == 8'h00 && !ready && !overflow && !fill_buf && !drain_buf,
        "R1 reset state", {status, ready, overflow, fill_buf, drain_buf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'h00, "R1 status after release", status, 0);

    // done while empty: ignored
    done = 1'b1; @(negedge clk); done = 1'b0;
    chk(status == 8'h00 && !ready, "R6 done when empty", status, 0);

    // near-exhaustive sweep across counter wrap
    for (int k = 0; k < 48; k++) begin
      push(k);
      if (k % 3 != 0 && occ() < 2) push(100 + k);
      if (occ() == 2) begin
        logic [16:0] len_before;
        logic [31:0] tag_before;
        len_before = len;
        tag_before = rd_data;
        ring();
        host_wr(4'd0, 32'h0000_FFFF);
        host_wr(4'd2, 32'hDEAD_BEEF);
        rd_addr = 4'd2;
        #1;
        chk(len == len_before, "R4 len kept when full", len, len_before);
        chk(rd_data == exp_tag[exp_out & 1], "R4 data kept when full", rd_data, tag_before);
      end
      drain();
      if (k % 4 == 3) while (occ() != 0) drain();
    end
    while (occ() != 0) drain();
    chk(!ready, "R5 empty idles", ready, 0);
    chk(exp_in > 32, "R9 wrapped twice", exp_in, 33);

    // length rounding at the top of the 16-bit range
    host_wr(4'd0, 32'h0000_FFFE);
    ring();
    chk(len == 17'h1_0000, "R7 no wrap", len, 17'h1_0000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule